// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets a processor reach the extended register space of external PHYs over a two-wire management bus. Software writes a 16-bit register address into an address register and then writes a management register with the port address, the device address, an opcode and, for writes, the data. That one write starts a fixed two-frame sequence on the wire. An address frame carries the register address. A data frame then either writes the data or reads a 16-bit value back from the PHY.

The management register reports progress. The busy bit stays high for the whole sequence. When a read completes, the read-valid bit rises and the returned data appears in the low half of the register. The block drives MDC as a free-running clock of `2*MDC_HALF` system clocks per period. MDIO is driven through an output/enable pair, so the pad logic outside the block provides the tristate buffer and the pull-up.

The sequencer state machine has these states and transitions:
- `SQ_IDLE`: waits for a launch, which is a management write that carries a valid opcode.
- `SQ_ADDR_GO`: hands the address frame to the shifter.
- `SQ_ADDR_RUN`: waits for that frame to finish.
- `SQ_DATA_GO`: hands over the write or read frame.
- `SQ_DATA_RUN`: waits for the end of that frame and then returns to `SQ_IDLE`.

The frame shifter has three states:
- `FS_IDLE`: takes the start request.
- `FS_ARMED`: waits for the next MDC falling edge.
- `FS_SHIFT`: presents one bit per falling edge and returns to `FS_IDLE` one falling edge after the last bit.

Top module: `c45_mgmt_master`

## Requirements
- R1: After reset, the management register reads 0, the address register reads 0 and `mdio_oe` is 0.
- R2: The address register sits at offset 0x8. Its bits 15:0 hold a 16-bit register address, which can be written and read back. Its bits 31:16 read 0.
- R3: The management register sits at offset 0x0 with this layout: bits 15:0 data, 20:16 port address, 25:21 device address, 28:26 opcode, 29 read-valid, 30 busy and 31 zero.
- R4: A management write while idle with opcode 5 (write) or 7 (read) starts an access. Any other opcode is ignored: the register keeps its value and no frame is sent.
- R5: The first frame of every access is at least 32 ones, then start 00, opcode 00, port (5 bits, MSB first), device (5 bits), turnaround 10, and the address-register value captured at launch (16 bits, MSB first).
- R6: For a write, the second frame is at least 32 ones, then 00, 01, port, device, 10, and the 16-bit write data.
- R7: For a read, the second frame is 00, 11, port, device. The master then releases MDIO for the 2 turnaround bits and the 16 data bits, and samples each data bit MSB first just before the MDC rising edge. On completion the data is in bits 15:0 and read-valid is 1.
- R8: Busy reads 1 from the cycle after the launching write until both frames have been fully clocked on the wire.
- R9: A management write while busy is ignored: the port, device, opcode and data fields and the frames on the wire are unchanged.
- R10: Read-valid is 0 while an access is in progress and after a write access.
- R11: MDC has a period of `2*MDC_HALF` clocks. `mdio_o` and `mdio_oe` change only on an MDC falling transition, and MDIO is released whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | ADDR_W | Register byte offset (0x0 management, 0x8 address) |
| csr_we | input | 1 | Register write strobe, one cycle |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, 1 = master drives |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
The hardest cases to reach are those that depend on where the access stands on the wire. One is a management write that lands in the middle of a running access. Another is the release of MDIO during the read turnaround and data bits. The bench places a behavioural PHY on the line that decodes the start, opcode and addresses of each frame as they arrive. When it sees a read opcode, it drives the turnaround zero and an address-dependent data word from the MDC falling edges. A second management write is issued a fixed number of clocks into a read, while the address frame is still shifting. The scoreboard then requires exactly the original two frames and the original fields.

// File: rtl/c45_pkg.sv
package c45_pkg;

    localparam logic [2:0] OPC_WRITE = 3'd5;
    localparam logic [2:0] OPC_READ  = 3'd7;

    localparam logic [1:0] START_EXT  = 2'b00;
    localparam logic [1:0] FOP_ADDR   = 2'b00;
    localparam logic [1:0] FOP_WRITE  = 2'b01;
    localparam logic [1:0] FOP_READ   = 2'b11;
    localparam logic [1:0] TURN_DRIVE = 2'b10;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR_GO,
        SQ_ADDR_RUN,
        SQ_DATA_GO,
        SQ_DATA_RUN
    } seq_state_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ARMED,
        FS_SHIFT
    } fs_state_t;

    function automatic logic [31:0] build_frame(
        input logic [1:0]  fop,
        input logic [4:0]  prt,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        return {START_EXT, fop, prt, dev, TURN_DRIVE, payload};
    endfunction

endpackage

// File: rtl/c45_mdc_gen.sv
module c45_mdc_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc_o,
    output logic fall_tick_o,
    output logic rise_tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_o <= ~mdc_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The tick is high in the cycle whose edge moves MDC.
    assign fall_tick_o = wrap &&  mdc_o;
    assign rise_tick_o = wrap && !mdc_o;

endmodule

// File: rtl/c45_frame_shifter.sv
module c45_frame_shifter
    import c45_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall_tick_i,
    input  logic        rise_tick_i,
    input  logic        start_i,
    input  logic        is_read_i,
    input  logic [31:0] frame_i,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done_o,
    output logic        active_o,
    output logic [15:0] rdata_o
);
    localparam int TOTAL  = PRE_LEN + 32;
    localparam int IW     = $clog2(TOTAL + 1);
    localparam int REL_AT = PRE_LEN + 14;
    localparam int DAT_AT = PRE_LEN + 16;

    fs_state_t        st_q, st_d;
    logic [TOTAL-1:0] sh_q;
    logic [IW-1:0]    idx_q;
    logic             rd_q;
    logic             last_bit;

    assign last_bit = (idx_q == IW'(TOTAL));
    assign active_o = (st_q != FS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE:  if (start_i)                 st_d = FS_ARMED;
            FS_ARMED: if (fall_tick_i)             st_d = FS_SHIFT;
            FS_SHIFT: if (fall_tick_i && last_bit) st_d = FS_IDLE;
            default:                               st_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done_o  <= 1'b0;
            rdata_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                FS_IDLE: begin
                    if (start_i) begin
                        sh_q  <= {{PRE_LEN{1'b1}}, frame_i};
                        rd_q  <= is_read_i;
                        idx_q <= '0;
                    end
                end
                FS_ARMED, FS_SHIFT: begin
                    if (fall_tick_i) begin
                        if (last_bit) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b1;
                            done_o  <= 1'b1;
                        end else begin
                            mdio_o  <= sh_q[TOTAL-1];
                            sh_q    <= sh_q << 1;
                            mdio_oe <= !(rd_q && (idx_q >= IW'(REL_AT)));
                            idx_q   <= idx_q + 1'b1;
                        end
                    end else if (rise_tick_i && st_q == FS_SHIFT && rd_q
                                 && idx_q > IW'(DAT_AT)) begin
                        rdata_o <= {rdata_o[14:0], mdio_i};
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $past(fall_tick_i)); // R11

endmodule

// File: rtl/c45_access_seq.sv
module c45_access_seq
    import c45_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_we_i,
    input  logic        addr_we_i,
    input  logic [31:0] wdata_i,
    input  logic        fs_done_i,
    input  logic [15:0] fs_rdata_i,
    output logic        fs_start_o,
    output logic        fs_read_o,
    output logic [31:0] fs_frame_o,
    output logic        busy_o,
    output logic        rvalid_o,
    output logic [2:0]  opc_o,
    output logic [4:0]  dev_o,
    output logic [4:0]  prt_o,
    output logic [15:0] data_o,
    output logic [15:0] regaddr_o
);
    seq_state_t  st_q, st_d;
    logic [15:0] addr_lat_q;
    logic [2:0]  new_opc;
    logic        launch;

    assign new_opc = wdata_i[28:26];
    assign launch  = mgmt_we_i && (st_q == SQ_IDLE)
                     && (new_opc == OPC_WRITE || new_opc == OPC_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:     if (launch)    st_d = SQ_ADDR_GO;
            SQ_ADDR_GO:                 st_d = SQ_ADDR_RUN;
            SQ_ADDR_RUN: if (fs_done_i) st_d = SQ_DATA_GO;
            SQ_DATA_GO:                 st_d = SQ_DATA_RUN;
            SQ_DATA_RUN: if (fs_done_i) st_d = SQ_IDLE;
            default:                    st_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        fs_start_o = (st_q == SQ_ADDR_GO) || (st_q == SQ_DATA_GO);
        fs_read_o  = (st_q == SQ_DATA_GO) && (opc_o == OPC_READ);
        if (st_q == SQ_ADDR_GO)
            fs_frame_o = build_frame(FOP_ADDR, prt_o, dev_o, addr_lat_q);
        else
            fs_frame_o = build_frame((opc_o == OPC_READ) ? FOP_READ : FOP_WRITE,
                                     prt_o, dev_o, data_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            rvalid_o   <= 1'b0;
            opc_o      <= '0;
            dev_o      <= '0;
            prt_o      <= '0;
            data_o     <= '0;
            regaddr_o  <= '0;
            addr_lat_q <= '0;
        end else begin
            if (addr_we_i) regaddr_o <= wdata_i[15:0];
            if (launch) begin
                opc_o      <= new_opc;
                dev_o      <= wdata_i[25:21];
                prt_o      <= wdata_i[20:16];
                data_o     <= wdata_i[15:0];
                addr_lat_q <= regaddr_o;
                rvalid_o   <= 1'b0;
                busy_o     <= 1'b1;
            end else if (st_q == SQ_DATA_RUN && fs_done_i) begin
                busy_o <= 1'b0;
                if (opc_o == OPC_READ) begin
                    data_o   <= fs_rdata_i;
                    rvalid_o <= 1'b1;
                end
            end
        end
    end

    AST_RVALID_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rvalid_o); // R10

    AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mgmt_we_i) |=> ($stable(prt_o) && $stable(dev_o) && $stable(opc_o))); // R9

    AST_RVALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid_o) |-> (opc_o == OPC_READ)); // R7

endmodule

// File: rtl/c45_mgmt_master.sv
module c45_mgmt_master
    import c45_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MDC_HALF = 2,
    parameter int PRE_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam logic [ADDR_W-1:0] OFS_MGMT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(8);

    logic        fall_tick, rise_tick;
    logic        fs_start, fs_read, fs_done, fs_active;
    logic [31:0] fs_frame;
    logic [15:0] fs_rdata;
    logic        busy, rvalid;
    logic [2:0]  opc;
    logic [4:0]  dev, prt;
    logic [15:0] data, regaddr;

    c45_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
        .clk         (clk),
        .rst_n       (rst_n),
        .mdc_o       (mdc),
        .fall_tick_o (fall_tick),
        .rise_tick_o (rise_tick)
    );

    c45_access_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_we_i  (csr_we && csr_addr == OFS_MGMT),
        .addr_we_i  (csr_we && csr_addr == OFS_ADDR),
        .wdata_i    (csr_wdata),
        .fs_done_i  (fs_done),
        .fs_rdata_i (fs_rdata),
        .fs_start_o (fs_start),
        .fs_read_o  (fs_read),
        .fs_frame_o (fs_frame),
        .busy_o     (busy),
        .rvalid_o   (rvalid),
        .opc_o      (opc),
        .dev_o      (dev),
        .prt_o      (prt),
        .data_o     (data),
        .regaddr_o  (regaddr)
    );

    c45_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_tick_i (fall_tick),
        .rise_tick_i (rise_tick),
        .start_i     (fs_start),
        .is_read_i   (fs_read),
        .frame_i     (fs_frame),
        .mdio_i      (mdio_i),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done_o      (fs_done),
        .active_o    (fs_active),
        .rdata_o     (fs_rdata)
    );

    always_comb begin
        unique case (csr_addr)
            OFS_MGMT: csr_rdata = {1'b0, busy, rvalid, opc, dev, prt, data};
            OFS_ADDR: csr_rdata = {16'h0000, regaddr};
            default:  csr_rdata = '0;
        endcase
    end

    AST_BUSY_COVERS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        fs_active |-> busy); // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R11

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc)); // R11

endmodule

// File: tb/sim_c45_mgmt_master.sv
module sim_c45_mgmt_master;
    localparam int CLK_PERIOD = 10;
    localparam int MDC_HALF   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    wire         mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    logic [31:0] exp_q[$];

    c45_mgmt_master #(.ADDR_W(4), .MDC_HALF(MDC_HALF), .PRE_LEN(32)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] d, input logic [15:0] a);
        return a ^ {p, d, 6'h2B};
    endfunction

    function automatic logic [31:0] mgmt_word(input logic b, input logic rv, input logic [2:0] op,
                                              input logic [4:0] d, input logic [4:0] p, input logic [15:0] v);
        return {1'b0, b, rv, op, d, p, v};
    endfunction

    // Monitor and PHY model
    int          ones = 0;
    int          nbits = 0;
    bit          capturing = 0;
    bit          phy_rd = 0;
    logic [31:0] cap = '0;
    logic [15:0] last_addr = '0;
    logic [15:0] phy_data = '0;

    always @(posedge mdc) begin
        if (!capturing) begin
            if (mdio_line) ones++;
            else if (ones >= 32) begin
                capturing = 1;
                cap = 32'h0;
                nbits = 1;
            end else ones = 0;
        end else begin
            cap = {cap[30:0], mdio_line};
            nbits++;
            if (phy_rd && nbits >= 16)
                check(!mdio_oe, "R7 released during read", {31'b0, mdio_oe}, 32'h0);
            if (nbits == 14 && cap[11:10] == 2'b11) begin
                phy_rd = 1;
                phy_data = phy_val(cap[9:5], cap[4:0], last_addr);
            end
            if (nbits == 32) begin
                if (exp_q.size() == 0)
                    check(0, "R4/R9 unexpected frame", cap, 32'hxxxxxxxx);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(cap === e, "R5/R6/R7 frame", cap, e);
                end
                if (cap[29:28] == 2'b00) last_addr = cap[15:0];
                frames_seen++;
                capturing = 0;
                phy_rd = 0;
                ones = 0;
            end
        end
    end

    always @(negedge mdc) begin
        if (phy_rd && nbits >= 15 && nbits <= 31) begin
            phy_en  = 1;
            phy_bit = (nbits == 15) ? 1'b0 : phy_data[31-nbits];
        end else begin
            phy_en  = 0;
            phy_bit = 1'b1;
        end
    end

    task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    // Driver: loads the address, pushes expected frames, launches.
    task automatic start_access(input bit rd, input logic [4:0] p, input logic [4:0] d,
                                input logic [15:0] a, input logic [15:0] v);
        csr_write(4'h8, {16'h0, a});
        exp_q.push_back({2'b00, 2'b00, p, d, 2'b10, a});
        if (rd) exp_q.push_back({2'b00, 2'b11, p, d, 2'b10, phy_val(p, d, a)});
        else    exp_q.push_back({2'b00, 2'b01, p, d, 2'b10, v});
        csr_write(4'h0, {1'b0, 1'b0, 1'b0, rd ? 3'd7 : 3'd5, d, p, v});
    endtask

    task automatic wait_idle(input int base);
        logic [31:0] r;
        int i;
        r = 32'h4000_0000;
        for (i = 0; i < 4000 && r[30]; i++) csr_read(4'h0, r);
        check(frames_seen == base + 2, "R8 busy until second frame ends", frames_seen, base + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        csr_read(4'h0, r); check(r == 0, "R1 mgmt after reset", r, 0);
        csr_read(4'h8, r); check(r == 0, "R1 addr after reset", r, 0);
        check(!mdio_oe, "R1 mdio released", {31'b0, mdio_oe}, 0);

        // R11 MDC period
        begin
            realtime t0;
            @(posedge mdc); t0 = $realtime;
            @(posedge mdc);
            check(($realtime - t0) == 2*MDC_HALF*CLK_PERIOD, "R11 mdc period",
                  int'($realtime - t0), 2*MDC_HALF*CLK_PERIOD);
        end

        // R2 address register
        csr_write(4'h8, 32'hFFFF_A5A5);
        csr_read(4'h8, r); check(r == 32'h0000_A5A5, "R2 addr readback", r, 32'h0000_A5A5);

        // R3/R6/R8 write access
        base = frames_seen;
        start_access(0, 5'd7, 5'd3, 16'h1234, 16'hBEEF);
        csr_read(4'h0, r);
        check(r == mgmt_word(1, 0, 3'd5, 5'd3, 5'd7, 16'hBEEF), "R8 R3 busy after launch", r,
              mgmt_word(1, 0, 3'd5, 5'd3, 5'd7, 16'hBEEF));
        wait_idle(base);
        csr_read(4'h0, r);
        check(r == mgmt_word(0, 0, 3'd5, 5'd3, 5'd7, 16'hBEEF), "R10 write done no rvalid", r,
              mgmt_word(0, 0, 3'd5, 5'd3, 5'd7, 16'hBEEF));
        check(!mdio_oe, "R11 released when idle", {31'b0, mdio_oe}, 0);

        // R7 read access
        base = frames_seen;
        start_access(1, 5'h1F, 5'h1E, 16'h00C1, 16'h0000);
        wait_idle(base);
        csr_read(4'h0, r);
        check(r == mgmt_word(0, 1, 3'd7, 5'h1E, 5'h1F, phy_val(5'h1F, 5'h1E, 16'h00C1)),
              "R7 read data and rvalid", r,
              mgmt_word(0, 1, 3'd7, 5'h1E, 5'h1F, phy_val(5'h1F, 5'h1E, 16'h00C1)));

        // R10 rvalid clears at a new launch
        base = frames_seen;
        start_access(0, 5'd1, 5'd2, 16'h8001, 16'h0F0F);
        csr_read(4'h0, r);
        check(r[29] == 1'b0 && r[30] == 1'b1, "R10 rvalid cleared on launch", r[31:29], 3'b010);
        wait_idle(base);

        // R9 write while busy ignored
        base = frames_seen;
        start_access(1, 5'd2, 5'd1, 16'h0F0F, 16'h0000);
        repeat (100) @(negedge clk);
        csr_write(4'h0, {3'b000, 3'd5, 5'd9, 5'd9, 16'h1111});
        csr_read(4'h0, r);
        check(r == mgmt_word(1, 0, 3'd7, 5'd1, 5'd2, 16'h0000), "R9 fields held while busy", r,
              mgmt_word(1, 0, 3'd7, 5'd1, 5'd2, 16'h0000));
        wait_idle(base);
        csr_read(4'h0, r);
        check(r == mgmt_word(0, 1, 3'd7, 5'd1, 5'd2, phy_val(5'd2, 5'd1, 16'h0F0F)),
              "R9 original read completes", r,
              mgmt_word(0, 1, 3'd7, 5'd1, 5'd2, phy_val(5'd2, 5'd1, 16'h0F0F)));

        // R4 invalid opcode ignored
        base = frames_seen;
        csr_write(4'h0, {3'b000, 3'd3, 5'd4, 5'd4, 16'h2222});
        csr_read(4'h0, r);
        check(r == mgmt_word(0, 1, 3'd7, 5'd1, 5'd2, phy_val(5'd2, 5'd1, 16'h0F0F)),
              "R4 invalid opcode keeps register", r,
              mgmt_word(0, 1, 3'd7, 5'd1, 5'd2, phy_val(5'd2, 5'd1, 16'h0F0F)));
        repeat (700) @(negedge clk);
        check(frames_seen == base, "R4 no frame for invalid opcode", frames_seen, base);
        check(exp_q.size() == 0, "R5 all expected frames seen", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule